// File: doc/BRIEF.md
# Maskable Interrupt Router Controller

This block collects level-sensitive interrupt requests from on-chip peripherals and steers each of them onto one of a small set of processor interrupt lines. Every source first passes through a two-flop synchronizer. The synchronized levels are visible in a read-only status register. A source is pending when its status bit and its enable bit in the mask register are both 1.

Each source has a small routing field that names the processor line it drives. A processor line is asserted while at least one pending source is routed to it. Nothing is latched and nothing needs to be acknowledged. When a source drops, or when software disables it, the line falls on its own.

Software reaches the registers through a plain single-cycle register port. The port has a write strobe, a read strobe, a word address and a 32-bit data bus in each direction. Read data is combinational and is valid while the read strobe is high. The block contains no state machine: it is a register file, a synchronizer stage and a registered combining network.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset the mask and all four routing registers are zero, every output line is low, and every register reads as zero while the sources are low.
- R2: Word address 0 (byte offset 0x00) is the 32-bit mask register. It is read/write, and bit n enables source n.
- R3: Word address 1 (byte offset 0x04) is the status register. Its bit n reads the level of source n as it was two clocks earlier. Writes to it change no register.
- R4: Word addresses 2 to 5 (byte offsets 0x08 to 0x14) are routing registers and are read/write. Address 5 holds sources 0 to 7, address 4 holds sources 8 to 15, address 3 holds sources 16 to 23, and address 2 holds sources 24 to 31. Source s uses bits [4*(s mod 8)+3 : 4*(s mod 8)] of its register.
- R5: Output line v is high exactly when some source is pending and its routing field equals v. A source is pending when its mask bit and status bit are both 1.
- R6: A routing field of 0, or any field with bit 3 set, connects the source to no line. Output line 0 is therefore always low.
- R7: A change on a source input reaches the output lines three clocks later. A write to the mask or routing registers reaches the output lines two clocks after the write cycle's edge, that is, one clock after the register updates.
- R8: An output line falls once the sources that held it high drop. The line follows the sources' level and is never latched.
- R9: While the read strobe is low the read data is zero. Word addresses 6 and 7 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Level interrupt requests; bit n is source n |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data; zero while rd_en is low |
| irq_o | output | 8 | Processor interrupt lines; bit v is line v |

## Verification
The bench builds the block with its default parameters: 32 sources, 8 lines, 4-bit fields and a 32-bit bus. With these values the reversed word order of the routing registers, the reserved field codes 8 to 15 and the unused line 0 are all reachable. Directed sequences measure the three-clock input latency and the two-clock register latency edge by edge. A long random phase then mixes source toggles with rewrites of the mask and routing registers, and a behavioural model checks the outputs and the read data on every clock.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    // Word address map; the routing words start right after status.
    localparam int ADDR_W     = 3;
    localparam int ROUTE_BASE = 2;
    localparam logic [ADDR_W-1:0] A_MASK = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
    import irq_route_pkg::*;
#(
    parameter int NSRC    = 32,
    parameter int DATA_W  = 32,
    parameter int FIELD_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [NSRC-1:0]         status_i,
    output logic [DATA_W-1:0]       rd_data,
    output logic [NSRC-1:0]         mask_o,
    output logic [NSRC*FIELD_W-1:0] route_o
);
    localparam int NROUTE = (NSRC * FIELD_W) / DATA_W;
    localparam int ROUTE_LAST = ROUTE_BASE + NROUTE - 1;

    logic [NSRC-1:0]   mask_q;
    logic [DATA_W-1:0] word_v [NROUTE];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_en && addr == A_MASK) begin
            mask_q <= wr_data[NSRC-1:0];
        end
    end

    // Word k holds source group NROUTE-1-k (reverse order).
    for (genvar k = 0; k < NROUTE; k++) begin : g_word
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en && addr == ADDR_W'(ROUTE_BASE + k)) begin
                q <= wr_data;
            end
        end
        assign word_v[k] = q;
        assign route_o[(NROUTE-1-k)*DATA_W +: DATA_W] = q;
    end

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            if (addr == A_MASK) begin
                rd_data[NSRC-1:0] = mask_q;
            end else if (addr == A_STAT) begin
                rd_data[NSRC-1:0] = status_i;
            end
            for (int k = 0; k < NROUTE; k++) begin
                if (addr == ADDR_W'(ROUTE_BASE + k)) begin
                    rd_data = word_v[k];
                end
            end
        end
    end

    assign mask_o = mask_q;

    assert_mask_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_MASK) |=> (mask_o == $past(wr_data[NSRC-1:0])));

    assert_status_ro_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_STAT) |=> ($stable(mask_o) && $stable(route_o)));

    assert_low_group_last_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(ROUTE_LAST)) |=> (route_o[DATA_W-1:0] == $past(wr_data)));

    assert_unmapped_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr > ADDR_W'(ROUTE_LAST)) |=> ($stable(mask_o) && $stable(route_o)));
endmodule

// File: rtl/irq_router.sv
module irq_router #(
    parameter int NSRC    = 32,
    parameter int NLINE   = 8,
    parameter int FIELD_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NSRC-1:0]         mask_i,
    input  logic [NSRC-1:0]         status_i,
    input  logic [NSRC*FIELD_W-1:0] route_i,
    output logic [NLINE-1:0]        line_o
);
    logic [NSRC-1:0]  pending;
    logic [NLINE-1:0] hit;
    logic [NLINE-1:0] line_q;

    assign pending = mask_i & status_i;

    // Code 0 and codes at or above NLINE never match a driven line.
    for (genvar j = 0; j < NLINE; j++) begin : g_line
        if (j == 0) begin : g_idle
            assign hit[j] = 1'b0;
        end else begin : g_drv
            logic [NSRC-1:0] sel;
            always_comb begin
                for (int s = 0; s < NSRC; s++) begin
                    sel[s] = (route_i[s*FIELD_W +: FIELD_W] == FIELD_W'(j));
                end
            end
            assign hit[j] = |(sel & pending);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
        end else begin
            line_q <= hit;
        end
    end

    assign line_o = line_q;

    assert_mask_off_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i == '0) |=> (line_o == '0));

    assert_line0_never_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !line_o[0]);

    assert_level_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_i == '0) |=> (line_o == '0));
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int NSRC    = 32,
    parameter int NLINE   = 8,
    parameter int FIELD_W = 4,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [NLINE-1:0]  irq_o
);
    localparam int RW = NSRC * FIELD_W;

    logic [NSRC-1:0] status;
    logic [NSRC-1:0] mask;
    logic [RW-1:0]   route;

    irq_sync #(.W(NSRC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (src_i),
        .q_o   (status)
    );

    irq_regfile #(.NSRC(NSRC), .DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wr_data  (wr_data),
        .status_i (status),
        .rd_data  (rd_data),
        .mask_o   (mask),
        .route_o  (route)
    );

    irq_router #(.NSRC(NSRC), .NLINE(NLINE), .FIELD_W(FIELD_W)) u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .mask_i   (mask),
        .status_i (status),
        .route_i  (route),
        .line_o   (irq_o)
    );
endmodule

// File: tb/sim_irq_route_ctrl.sv
module sim_irq_route_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [7:0]  irq_o;

    int n_chk = 0;
    int n_err = 0;
    bit cmp_en = 1'b0;

    always #10 clk = ~clk;

    irq_route_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o)
    );

    // Behavioural reference state
    logic [31:0] m_mask, m_stat, m_s1;
    logic [31:0] m_route [4];   // index = word address - 2
    logic [7:0]  m_out;

    function automatic logic [7:0] ref_lines(input logic [31:0] msk, input logic [31:0] st);
        logic [7:0] r = '0;
        for (int s = 0; s < 32; s++) begin
            if (msk[s] && st[s]) begin
                int w = 3 - s / 8;
                int f = int'(m_route[w][4*(s%8) +: 4]);
                if (f >= 1 && f <= 7) r[f] = 1'b1;
            end
        end
        return r;
    endfunction

    function automatic logic [31:0] ref_read(input logic re, input logic [2:0] a);
        if (!re) return '0;
        case (a)
            3'd0: return m_mask;
            3'd1: return m_stat;
            3'd2, 3'd3, 3'd4, 3'd5: return m_route[int'(a) - 2];
            default: return '0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mask = '0; m_stat = '0; m_s1 = '0; m_out = '0;
            for (int i = 0; i < 4; i++) m_route[i] = '0;
        end else begin
            m_out  = ref_lines(m_mask, m_stat);
            m_stat = m_s1;
            m_s1   = src_i;
            if (wr_en) begin
                if (addr == 3'd0) m_mask = wr_data;
                else if (addr >= 3'd2 && addr <= 3'd5) m_route[int'(addr) - 2] = wr_data;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            chk(irq_o == m_out, "R5 R7 per-clock lines", {24'h0, irq_o}, {24'h0, m_out});
            chk(rd_data == ref_read(rd_en, addr), "R2 R3 R4 R9 per-clock read", rd_data, ref_read(rd_en, addr));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); #2;
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk); #2;
        rd_en = 1'b1; addr = a;
        #3 v = rd_data;
        #1 rd_en = 1'b0;
    endtask

    task automatic set_src(input logic [31:0] v);
        @(negedge clk); #2;
        src_i = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        #2 rst_n = 1'b1;
        cmp_en = 1'b1;

        // R1: reset state
        idle(1);
        chk(irq_o == 8'h0, "R1 lines after reset", {24'h0, irq_o}, 32'h0);
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk(v == 32'h0, "R1 register after reset", v, 32'h0);
        end

        // R2: mask read/write
        wr(3'd0, 32'h1234_5678);
        rd(3'd0, v);
        chk(v == 32'h1234_5678, "R2 mask readback", v, 32'h1234_5678);
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, v);
        chk(v == 32'hFFFF_FFFF, "R2 mask all ones", v, 32'hFFFF_FFFF);

        // R4: routing words in reverse group order
        wr(3'd5, 32'h7654_3210);    // sources 0..7 -> lines 0..7
        wr(3'd4, 32'h0000_0092);    // source 8 -> 2, source 9 -> reserved 9
        wr(3'd2, 32'h0000_0005);    // source 24 -> 5
        rd(3'd5, v);
        chk(v == 32'h7654_3210, "R4 word 5 readback", v, 32'h7654_3210);
        rd(3'd4, v);
        chk(v == 32'h0000_0092, "R4 word 4 readback", v, 32'h0000_0092);
        rd(3'd2, v);
        chk(v == 32'h0000_0005, "R4 word 2 readback", v, 32'h0000_0005);

        // R7: input latency of three clocks
        set_src(32'h0000_0008);
        @(negedge clk);
        chk(irq_o == 8'h00, "R7 one clock after input", {24'h0, irq_o}, 32'h0);
        @(negedge clk);
        chk(irq_o == 8'h00, "R7 two clocks after input", {24'h0, irq_o}, 32'h0);
        @(negedge clk);
        chk(irq_o == 8'h08, "R7 three clocks after input", {24'h0, irq_o}, 32'h8);

        // R8: level release
        set_src(32'h0);
        idle(2);
        chk(irq_o == 8'h08, "R8 still high two clocks after drop", {24'h0, irq_o}, 32'h8);
        idle(1);
        chk(irq_o == 8'h00, "R8 released three clocks after drop", {24'h0, irq_o}, 32'h0);

        // R4: source 24 sits in word 2 bits 3:0
        set_src(32'h0100_0000);
        idle(3);
        chk(irq_o == 8'h20, "R4 source 24 to line 5", {24'h0, irq_o}, 32'h20);
        set_src(32'h0100_0100);     // add source 8 -> line 2
        idle(3);
        chk(irq_o == 8'h24, "R5 two sources two lines", {24'h0, irq_o}, 32'h24);
        set_src(32'h0);
        idle(4);

        // R6: field 0 and reserved field drive nothing
        set_src(32'h0000_0201);
        idle(4);
        chk(irq_o == 8'h00, "R6 field 0 and reserved field", {24'h0, irq_o}, 32'h0);

        // R3: status read-only and reflects inputs
        rd(3'd1, v);
        chk(v == 32'h0000_0201, "R3 status reflects sources", v, 32'h201);
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, v);
        chk(v == 32'h0000_0201, "R3 status after write", v, 32'h201);
        rd(3'd0, v);
        chk(v == 32'hFFFF_FFFF, "R3 mask untouched by status write", v, 32'hFFFF_FFFF);
        set_src(32'h0);
        idle(4);

        // R5/R7: masking and two-clock register latency
        set_src(32'h0000_0020);
        idle(4);
        chk(irq_o == 8'h20, "R5 enabled source drives line 5", {24'h0, irq_o}, 32'h20);
        wr(3'd0, 32'hFFFF_FFDF);
        chk(irq_o == 8'h20, "R7 one clock after mask write", {24'h0, irq_o}, 32'h20);
        @(negedge clk);
        chk(irq_o == 8'h00, "R5 R7 masked two clocks after write", {24'h0, irq_o}, 32'h0);
        wr(3'd0, 32'hFFFF_FFFF);
        idle(2);
        chk(irq_o == 8'h20, "R5 re-enabled", {24'h0, irq_o}, 32'h20);
        set_src(32'h0);
        idle(4);

        // R9: strobe low and unmapped words
        @(negedge clk); #2 addr = 3'd0;
        #3 chk(rd_data == 32'h0, "R9 read data with strobe low", rd_data, 32'h0);
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd7, 32'hFFFF_FFFF);
        rd(3'd6, v);
        chk(v == 32'h0, "R9 word 6 reads zero", v, 32'h0);
        rd(3'd7, v);
        chk(v == 32'h0, "R9 word 7 reads zero", v, 32'h0);
        rd(3'd5, v);
        chk(v == 32'h7654_3210, "R9 routing untouched", v, 32'h7654_3210);
        rd(3'd0, v);
        chk(v == 32'hFFFF_FFFF, "R9 mask untouched", v, 32'hFFFF_FFFF);

        // Random mix, checked every clock by the model
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk); #2;
            wr_en = 1'b0; rd_en = 1'b0;
            if ($urandom_range(0, 3) == 0) src_i = $urandom();
            case ($urandom_range(0, 7))
                0: begin wr_en = 1'b1; addr = 3'($urandom_range(0, 7)); wr_data = $urandom(); end
                1, 2: begin rd_en = 1'b1; addr = 3'($urandom_range(0, 7)); end
                default: ;
            endcase
        end
        @(negedge clk); #2;
        wr_en = 1'b0; rd_en = 1'b0;
        idle(4);
        finish_run();
    end
endmodule